// File: doc/BRIEF.md
# Wide-Integer Elementwise Route Decoder

This block looks at one two-source elementwise instruction record and decides which execution path handles it. There are four outcomes: a 64-bit integer arithmetic engine, a 64-bit bitwise engine, the ordinary path for 32-bit and narrower data, or an illegal-instruction error. The decision uses the opcode class byte, the ALU op byte, the packed pair of source datatype nibbles and the output datatype byte. It does not look at any width field. A 64-bit route is taken only when the exact 64-bit type codes appear on the operands, and only for an approved set of integer ops. One exception applies to shifts: a shift may take an unsigned 32-bit count.

Records enter through a valid/ready handshake and the verdict is registered for one cycle. The verdict is a one-hot route, a signedness flag, a flag marking the shift-count exception, and an error flag. The upstream instruction fetch stalls whenever the engine side is not ready.

Top module: `wdec`

## Requirements
- R1: A datatype counts as 64-bit only for the exact codes 0xC (signed) and 0x1 (unsigned). Source 0 is `in_dt_src[3:0]`, source 1 is `in_dt_src[7:4]`, and the output byte `in_dt_out` must equal 0x0C or 0x01. Any other code, including one with the same low nibble and a nonzero high nibble, counts as not 64-bit.
- R2: Class 0x41 takes the arithmetic route (`out_route` = 3'b001) when all three operands are 64-bit, the op is in the integer set and signedness agrees. In that case `out_signed` = 1 exactly when the output code is 0xC.
- R3: The integer set is 0xC4 to 0xDD without 0xCE, plus 0x1B. Any other op on class 0x41 with a 64-bit operand gives an error. This includes plain add 0x04, abs-value 0xCE, 0xC3 and the argmax/argmin codes 0xDE to 0xE1.
- R4: Ops 0xCB to 0xD4 (without 0xCE) need all three operands signed. Ops 0xD5 to 0xDD need all three unsigned. Shared ops (0xC4 to 0xCA and 0x1B) accept either signedness if all three agree. Any mismatch gives an error.
- R5: Class 0x51 takes the bitwise route (3'b010) when source 0, source 1 and the output carry the same 64-bit code. `out_signed` follows the output code.
- R6: A shift op (0x02, 0x03, 0x10, 0x11) on class 0x51 is also accepted when source 0 equals the 64-bit output code and source 1 is the unsigned 32-bit code (parameter, default 0x8). It then routes 3'b010 with `out_shift_cnt32` = 1. The same operand mix with a non-shift op gives an error.
- R7: On class 0x41 or 0x51 with no 64-bit operand, the route is the narrow path (3'b100) and the signed and shift flags are 0.
- R8: Any opcode class other than 0x41 and 0x51 gives an error.
- R9: An error verdict has `out_route` = 0 and `out_error` = 1. It is present only while `out_valid` is high, so with `out_ready` held high it lasts exactly one cycle.
- R10: `in_ready` is high when the output register is empty or being drained. A record accepted at one clock edge appears at the outputs after that edge. The verdict stays stable while `out_valid` is high and `out_ready` is low.
- R11: After reset, `out_valid` and all verdict outputs are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Record offered |
| in_ready | output | 1 | Record can be taken this cycle |
| in_opclass | input | 8 | Opcode class byte |
| in_op | input | 8 | ALU op byte |
| in_dt_src | input | 8 | Source datatypes: source 0 low nibble, source 1 high nibble |
| in_dt_out | input | 8 | Output datatype byte |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Verdict consumed this cycle |
| out_route | output | 3 | One-hot: bit0 arithmetic 64, bit1 bitwise 64, bit2 narrow; 0 on error |
| out_signed | output | 1 | 64-bit route uses the signed variant |
| out_shift_cnt32 | output | 1 | Shift count is an unsigned 32-bit source |
| out_error | output | 1 | Illegal record |

## Verification
Two things can happen in the same cycle: a held verdict waits under backpressure while the next record is already offered. The bench provokes this by lowering `out_ready` after one acceptance and presenting a second record at once. It then checks three things. First, `in_ready` drops. Second, the first verdict (a shift-exception bitwise result) stays unchanged. Third, when `out_ready` returns, draining the first verdict and accepting the second happen at the same edge, so the second verdict appears on the next cycle with nothing lost or duplicated.

// File: rtl/wdec_pkg.sv
package wdec_pkg;

    localparam int ROUTE_W = 3;
    localparam int RT_ARITH = 0;
    localparam int RT_BITS  = 1;
    localparam int RT_NARROW = 2;

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic               sgn;
        logic               shcnt;
        logic               err;
    } verdict_t;

    typedef struct packed {
        logic     vld;
        verdict_t res;
    } stage_t;

endpackage

// File: rtl/wdec_dtype_probe.sv
module wdec_dtype_probe #(
    parameter int          CODE_W = 8,
    parameter logic [3:0]  S64    = 4'hC,
    parameter logic [3:0]  U64    = 4'h1,
    parameter logic [3:0]  U32    = 4'h8
) (
    input  logic [CODE_W-1:0] code,
    output logic              is_s64,
    output logic              is_u64,
    output logic              is_u32
);
    localparam logic [CODE_W-1:0] S64_X = CODE_W'(S64);
    localparam logic [CODE_W-1:0] U64_X = CODE_W'(U64);
    localparam logic [CODE_W-1:0] U32_X = CODE_W'(U32);

    always_comb begin
        is_s64 = (code == S64_X);
        is_u64 = (code == U64_X);
        is_u32 = (code == U32_X);
    end
endmodule

// File: rtl/wdec_op_probe.sv
module wdec_op_probe #(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] op,
    output logic            int_op,
    output logic            shared_op,
    output logic            sgn_only,
    output logic            uns_only,
    output logic            shift_op
);
    localparam logic [OP_W-1:0] INT_LO   = OP_W'(8'hC4);
    localparam logic [OP_W-1:0] SHR_HI   = OP_W'(8'hCA);
    localparam logic [OP_W-1:0] SGN_HI   = OP_W'(8'hD4);
    localparam logic [OP_W-1:0] INT_HI   = OP_W'(8'hDD);
    localparam logic [OP_W-1:0] ABS_ONE  = OP_W'(8'hCE);
    localparam logic [OP_W-1:0] MOD_BASE = OP_W'(8'h1B);

    logic in_band;
    logic shared_band;
    logic sgn_band;
    logic uns_band;

    always_comb begin
        in_band     = (op >= INT_LO) && (op <= INT_HI) && (op != ABS_ONE);
        shared_band = (op >= INT_LO) && (op <= SHR_HI);
        sgn_band    = (op > SHR_HI) && (op <= SGN_HI) && (op != ABS_ONE);
        uns_band    = (op > SGN_HI) && (op <= INT_HI);

        int_op    = in_band || (op == MOD_BASE);
        shared_op = shared_band || (op == MOD_BASE);
        sgn_only  = sgn_band;
        uns_only  = uns_band;
        shift_op  = (op == OP_W'(8'h02)) || (op == OP_W'(8'h03)) ||
                    (op == OP_W'(8'h10)) || (op == OP_W'(8'h11));
    end
endmodule

// File: rtl/wdec_resolve.sv
module wdec_resolve
    import wdec_pkg::*;
#(
    parameter int          CLS_W      = 8,
    parameter logic [7:0]  CLS_ARITH  = 8'h41,
    parameter logic [7:0]  CLS_BITS   = 8'h51,
    parameter int          N_OPND     = 3
) (
    input  logic [CLS_W-1:0]  opclass,
    input  logic [N_OPND-1:0] s64,
    input  logic [N_OPND-1:0] u64,
    input  logic [N_OPND-1:0] u32,
    input  logic              int_op,
    input  logic              shared_op,
    input  logic              sgn_only,
    input  logic              uns_only,
    input  logic              shift_op,
    output verdict_t          verdict
);
    // operand index: 0 = source 0, 1 = source 1, N_OPND-1 = output
    localparam int OUT_I = N_OPND - 1;

    logic all_s;
    logic all_u;
    logic any64;
    logic arith_ok;
    logic src0_match;
    logic src1_match;
    logic bits_ident;
    logic bits_shift;

    always_comb begin
        all_s      = &s64;
        all_u      = &u64;
        any64      = |(s64 | u64);
        arith_ok   = int_op &&
                     ((all_s && (shared_op || sgn_only)) ||
                      (all_u && (shared_op || uns_only)));
        src0_match = (s64[0] && s64[OUT_I]) || (u64[0] && u64[OUT_I]);
        src1_match = (s64[1] && s64[OUT_I]) || (u64[1] && u64[OUT_I]);
        bits_ident = src0_match && src1_match;
        bits_shift = src0_match && shift_op && u32[1];

        verdict = '0;
        if (opclass == CLS_W'(CLS_ARITH)) begin
            if (arith_ok) begin
                verdict.route[RT_ARITH] = 1'b1;
                verdict.sgn             = s64[OUT_I];
            end else if (any64) begin
                verdict.err = 1'b1;
            end else begin
                verdict.route[RT_NARROW] = 1'b1;
            end
        end else if (opclass == CLS_W'(CLS_BITS)) begin
            if (bits_ident || bits_shift) begin
                verdict.route[RT_BITS] = 1'b1;
                verdict.sgn            = s64[OUT_I];
                verdict.shcnt          = !bits_ident;
            end else if (any64) begin
                verdict.err = 1'b1;
            end else begin
                verdict.route[RT_NARROW] = 1'b1;
            end
        end else begin
            verdict.err = 1'b1;
        end
    end
endmodule

// File: rtl/wdec.sv
module wdec
    import wdec_pkg::*;
#(
    parameter logic [3:0] DT_S64    = 4'hC,
    parameter logic [3:0] DT_U64    = 4'h1,
    parameter logic [3:0] DT_U32    = 4'h8,
    parameter logic [7:0] CLS_ARITH = 8'h41,
    parameter logic [7:0] CLS_BITS  = 8'h51
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_opclass,
    input  logic [7:0] in_op,
    input  logic [7:0] in_dt_src,
    input  logic [7:0] in_dt_out,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [2:0] out_route,
    output logic       out_signed,
    output logic       out_shift_cnt32,
    output logic       out_error
);
    localparam int N_OPND = 3;
    localparam int CODE_W = 8;
    localparam int NIB_W  = CODE_W / 2;

    logic [CODE_W-1:0] codes [N_OPND];
    logic [N_OPND-1:0] s64, u64, u32;
    logic int_op, shared_op, sgn_only, uns_only, shift_op;
    verdict_t verdict;
    stage_t   st_d, st_q;

    always_comb begin
        codes[0] = {{NIB_W{1'b0}}, in_dt_src[NIB_W-1:0]};
        codes[1] = {{NIB_W{1'b0}}, in_dt_src[CODE_W-1:NIB_W]};
        codes[2] = in_dt_out;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_probe
        wdec_dtype_probe #(
            .CODE_W(CODE_W), .S64(DT_S64), .U64(DT_U64), .U32(DT_U32)
        ) u_dt (
            .code   (codes[g]),
            .is_s64 (s64[g]),
            .is_u64 (u64[g]),
            .is_u32 (u32[g])
        );
    end

    wdec_op_probe #(.OP_W(8)) u_op (
        .op        (in_op),
        .int_op    (int_op),
        .shared_op (shared_op),
        .sgn_only  (sgn_only),
        .uns_only  (uns_only),
        .shift_op  (shift_op)
    );

    wdec_resolve #(
        .CLS_W(8), .CLS_ARITH(CLS_ARITH), .CLS_BITS(CLS_BITS), .N_OPND(N_OPND)
    ) u_res (
        .opclass   (in_opclass),
        .s64       (s64),
        .u64       (u64),
        .u32       (u32),
        .int_op    (int_op),
        .shared_op (shared_op),
        .sgn_only  (sgn_only),
        .uns_only  (uns_only),
        .shift_op  (shift_op),
        .verdict   (verdict)
    );

    assign in_ready = !st_q.vld || out_ready;

    always_comb begin
        st_d = st_q;
        if (in_ready) begin
            st_d.vld = in_valid;
            st_d.res = in_valid ? verdict : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid       = st_q.vld;
    assign out_route       = st_q.res.route;
    assign out_signed      = st_q.res.sgn;
    assign out_shift_cnt32 = st_q.res.shcnt;
    assign out_error       = st_q.res.err;
endmodule

// File: rtl/wdec_chk.sv
module wdec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [2:0] out_route,
    input logic       out_signed,
    input logic       out_shift_cnt32,
    input logic       out_error
);
    // R9
    err_no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_error |-> (out_route == 3'b000) && out_valid);

    // R2
    route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_error) |-> $onehot(out_route));

    // R6
    shift_on_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_shift_cnt32 |-> out_route[1]);

    // R7
    signed_wide_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_signed |-> (out_route[0] || out_route[1]));

    // R10
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_route) &&
            $stable(out_error) && $stable(out_signed) && $stable(out_shift_cnt32));

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R11
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_route == 3'b000) && !out_error && in_ready);
endmodule

bind wdec wdec_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_route       (out_route),
    .out_signed      (out_signed),
    .out_shift_cnt32 (out_shift_cnt32),
    .out_error       (out_error)
);

// File: tb/tb_wdec.sv
module tb_wdec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_opclass = '0, in_op = '0, in_dt_src = '0, in_dt_out = '0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [2:0] out_route;
    logic       out_signed, out_shift_cnt32, out_error;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    wdec dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opclass(in_opclass), .in_op(in_op), .in_dt_src(in_dt_src),
        .in_dt_out(in_dt_out), .out_valid(out_valid), .out_ready(out_ready),
        .out_route(out_route), .out_signed(out_signed),
        .out_shift_cnt32(out_shift_cnt32), .out_error(out_error)
    );

    // {class, op, src pair, out, route, signed, shift, error}
    localparam int NV = 24;
    localparam logic [37:0] VEC [NV] = '{
        {8'h41, 8'hC4, 8'hCC, 8'h0C, 3'b001, 1'b1, 1'b0, 1'b0}, // R2 signed add
        {8'h41, 8'hC4, 8'h11, 8'h01, 3'b001, 1'b0, 1'b0, 1'b0}, // R2 unsigned add
        {8'h41, 8'hCF, 8'h11, 8'h01, 3'b000, 1'b0, 1'b0, 1'b1}, // R4 signed max on unsigned
        {8'h41, 8'hD5, 8'h11, 8'h01, 3'b001, 1'b0, 1'b0, 1'b0}, // R4 unsigned max
        {8'h41, 8'hD5, 8'hCC, 8'h0C, 3'b000, 1'b0, 1'b0, 1'b1}, // R4 unsigned max on signed
        {8'h41, 8'h1B, 8'hCC, 8'h0C, 3'b001, 1'b1, 1'b0, 1'b0}, // R3 base mod in set
        {8'h41, 8'hCE, 8'hCC, 8'h0C, 3'b000, 1'b0, 1'b0, 1'b1}, // R3 abs-value excluded
        {8'h41, 8'hDE, 8'h11, 8'h01, 3'b000, 1'b0, 1'b0, 1'b1}, // R3 argmax excluded
        {8'h41, 8'h04, 8'hCC, 8'h0C, 3'b000, 1'b0, 1'b0, 1'b1}, // R3 plain add on 64-bit
        {8'h41, 8'hC4, 8'h8C, 8'h0C, 3'b000, 1'b0, 1'b0, 1'b1}, // R1 mixed width
        {8'h41, 8'hC4, 8'h1C, 8'h0C, 3'b000, 1'b0, 1'b0, 1'b1}, // R4 shared op mixed sign
        {8'h41, 8'hC4, 8'h88, 8'h08, 3'b100, 1'b0, 1'b0, 1'b0}, // R7 narrow arith
        {8'h51, 8'h10, 8'h8C, 8'h0C, 3'b010, 1'b1, 1'b1, 1'b0}, // R6 shift signed u32 count
        {8'h51, 8'h11, 8'h81, 8'h01, 3'b010, 1'b0, 1'b1, 1'b0}, // R6 shift unsigned u32 count
        {8'h51, 8'h20, 8'h8C, 8'h0C, 3'b000, 1'b0, 1'b0, 1'b1}, // R6 non-shift with u32 src1
        {8'h51, 8'h20, 8'hCC, 8'h0C, 3'b010, 1'b1, 1'b0, 1'b0}, // R5 bitwise identical signed
        {8'h51, 8'h02, 8'h11, 8'h01, 3'b010, 1'b0, 1'b0, 1'b0}, // R5 shift with identical types
        {8'h51, 8'h20, 8'h88, 8'h08, 3'b100, 1'b0, 1'b0, 1'b0}, // R7 narrow bitwise
        {8'h61, 8'hC4, 8'hCC, 8'h0C, 3'b000, 1'b0, 1'b0, 1'b1}, // R8 unknown class
        {8'h41, 8'hDD, 8'h11, 8'h01, 3'b001, 1'b0, 1'b0, 1'b0}, // R3 top of band
        {8'h41, 8'hC3, 8'h11, 8'h01, 3'b000, 1'b0, 1'b0, 1'b1}, // R3 below band
        {8'h51, 8'h03, 8'hC1, 8'h0C, 3'b000, 1'b0, 1'b0, 1'b1}, // R5 src0 differs from out
        {8'h41, 8'hC4, 8'h11, 8'h0C, 3'b000, 1'b0, 1'b0, 1'b1}, // R4 out signed, sources unsigned
        {8'h41, 8'hC4, 8'hCC, 8'h8C, 3'b000, 1'b0, 1'b0, 1'b1}  // R1 out byte high nibble set
    };

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] rec);
        in_opclass = rec[31:24];
        in_op      = rec[23:16];
        in_dt_src  = rec[15:8];
        in_dt_out  = rec[7:0];
        in_valid   = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset", {out_valid, out_route, out_error, in_ready, out_signed},
              {1'b0, 3'b000, 1'b0, 1'b1, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after release", {out_valid, out_route, out_error, in_ready, out_shift_cnt32},
              {1'b0, 3'b000, 1'b0, 1'b1, 1'b0});

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][37:6]);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R2-class vector %0d (see table tag)", i),
                  {out_valid, out_route, out_signed, out_shift_cnt32, out_error},
                  {1'b1, VEC[i][5:0]});
            @(negedge clk);
        end

        // R9 error lasts one cycle with out_ready high
        drive({8'h61, 8'h00, 8'h00, 8'h00});
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 error present", {3'b000, out_valid, out_error, out_route[1:0]},
              {3'b000, 1'b1, 1'b1, 2'b00});
        @(negedge clk);
        check("R9 error gone", {4'b0, out_valid, out_error, 1'b0},
              {4'b0, 1'b0, 1'b0, 1'b0});

        // R10 backpressure while next record waits
        out_ready = 1'b0;
        drive({8'h51, 8'h10, 8'h8C, 8'h0C});
        @(negedge clk);
        drive({8'h41, 8'hC4, 8'h11, 8'h01});
        check("R10 stall ready low", {6'b0, in_ready}, 7'b0);
        check("R6 held first", {out_valid, out_route, out_signed, out_shift_cnt32, out_error},
              {1'b1, 3'b010, 1'b1, 1'b1, 1'b0});
        @(negedge clk);
        check("R10 still held", {out_valid, out_route, out_signed, out_shift_cnt32, out_error},
              {1'b1, 3'b010, 1'b1, 1'b1, 1'b0});
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 second after drain", {out_valid, out_route, out_signed, out_shift_cnt32, out_error},
              {1'b1, 3'b001, 1'b0, 1'b0, 1'b0});
        @(negedge clk);
        check("R10 drained", {6'b0, out_valid}, 7'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule